// File: doc/BRIEF.md
# Smart Card Fault Supervisor and Deactivator

This block supervises a single smart card slot together with its supply switch. It filters the two card-detect inputs into a present/absent decision and enables the card supply at the host's request. It opens the gates on the card reset, clock and data lines only once the supply comparator reports a good level. The host keeps control of the detailed activation timing on the lines themselves. This block only decides whether each line may reach the card.

The block shuts the card down by itself, with no host action, when the card is pulled, the supply leaves its valid range or an over-current is flagged. The shutdown closes the reset gate, then the clock gate, then the data gate, and then switches the supply off, with one timer tick between steps. After such a shutdown the fault is latched on the active-low interrupt and the slot stays off until the host withdraws its activation request. A deactivation requested by the host follows the same ordered steps but latches no fault.

Top module: `sc_fault_supervisor`

## Requirements
- R1: The raw presence is `(det_hi_en & det_hi) | (det_lo_en & !det_lo_n)`. Presence is reported only after the raw presence has been high on DEB_CYCLES consecutive clock edges. `irq_n` is 1 exactly when presence is reported and no fault is latched, and it is 0 out of reset.
- R2: In the idle state, with presence reported and `cmd_act`=1, `vcc_en` rises on the next edge. `vcc_sel5` then takes the value of `cmd_sel5` (1 = 5 V, 0 = 3 V). While the supply ramps, `rst_gate`, `clk_gate`, `io_gate` and `rdy` stay 0.
- R3: During the ramp, `vcc_ok`=1 leads on the next edge to `rdy`=1 and all three gates at 1. `rdy` is 1 only in this active state.
- R4: While `vcc_en` is 1, changes on `cmd_sel5` have no effect on `vcc_sel5`.
- R5: A deactivation takes `rst_gate` to 0 on its first edge. `clk_gate` follows TICK_CYCLES edges later, `io_gate` another TICK_CYCLES edges later, and `vcc_en` another TICK_CYCLES edges later.
- R6: In the active state, raw absence, `vcc_ok`=0 or `ovc`=1 starts a fault deactivation on the next edge. During the ramp, raw absence or `ovc`=1 does the same.
- R7: If `cmd_act` falls while active, the block runs the same deactivation with no fault latched. It returns to idle TICK_CYCLES edges after `vcc_en` falls and can then be activated again.
- R8: A fault deactivation drives `irq_n` to 0 from its first edge. After the sequence, the block keeps `vcc_en` at 0 while `cmd_act` stays 1. The edge after `cmd_act` is seen at 0 clears the fault.
- R9: If a fault condition and the fall of `cmd_act` occur on the same edge, the block treats the event as a fault.
- R10: When the raw presence drops, the reported presence clears on the next edge, with no debounce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act | input | 1 | Host activation request |
| cmd_sel5 | input | 1 | Host voltage select, 1 = 5 V, 0 = 3 V |
| det_hi | input | 1 | Card detect, active high |
| det_lo_n | input | 1 | Card detect, active low |
| det_hi_en | input | 1 | Enables the active-high detect input |
| det_lo_en | input | 1 | Enables the active-low detect input |
| vcc_ok | input | 1 | Supply-in-range comparator flag |
| ovc | input | 1 | Over-current flag |
| irq_n | output | 1 | Active-low presence/fault interrupt |
| rdy | output | 1 | Supply ready, card active |
| vcc_en | output | 1 | Card supply enable |
| vcc_sel5 | output | 1 | Latched voltage code |
| rst_gate | output | 1 | Card reset line gate (1 = pass) |
| clk_gate | output | 1 | Card clock line gate (1 = pass) |
| io_gate | output | 1 | Card data line gate (1 = pass) |

## Verification
The host's deactivation request and an autonomous fault can arrive on the same clock edge. The bench provokes this by lowering `cmd_act` and raising `ovc` on the same falling edge while the card is active. It judges the outcome by `irq_n`: the interrupt must stay low through the whole ordered shutdown and in the locked state reached afterwards. It may rise only one edge later, because `cmd_act` is already low. A host-only deactivation leaves `irq_n` high, so the two outcomes are easy to tell apart.

// File: rtl/sc_sup_pkg.sv
package sc_sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_ACTIVE,
        ST_DEACT,
        ST_LOCK
    } sc_state_e;

    localparam int unsigned NUM_STEPS = 4;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    typedef struct packed {
        sc_state_e         state;
        logic [STEP_W-1:0] step;
        logic              fault;
        logic              sel5;
    } sc_ctrl_s;

endpackage

// File: rtl/sc_presence_filter.sv
module sc_presence_filter #(
    parameter int unsigned DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_hi,
    input  logic det_lo_n,
    input  logic det_hi_en,
    input  logic det_lo_en,
    output logic raw_present,
    output logic present_db
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pres;
    } flt_s;

    flt_s flt_d, flt_q;

    assign raw_present = (det_hi_en & det_hi) | (det_lo_en & ~det_lo_n);
    assign present_db  = flt_q.pres;

    always_comb begin
        flt_d = flt_q;
        if (!raw_present) begin
            flt_d.cnt  = '0;
            flt_d.pres = 1'b0;
        end else if (!flt_q.pres) begin
            if (flt_q.cnt == CW'(DEB_CYCLES - 1)) begin
                flt_d.pres = 1'b1;
                flt_d.cnt  = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end
endmodule

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
    parameter int unsigned TICK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = $clog2(TICK_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == TW'(TICK_CYCLES - 1));
    assign tick   = run & at_end;

    always_comb begin
        if (!run)        cnt_d = '0;
        else if (at_end) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sc_fault_supervisor.sv
module sc_fault_supervisor
    import sc_sup_pkg::*;
#(
    parameter int unsigned DEB_CYCLES  = 8,
    parameter int unsigned TICK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_act,
    input  logic cmd_sel5,
    input  logic det_hi,
    input  logic det_lo_n,
    input  logic det_hi_en,
    input  logic det_lo_en,
    input  logic vcc_ok,
    input  logic ovc,
    output logic irq_n,
    output logic rdy,
    output logic vcc_en,
    output logic vcc_sel5,
    output logic rst_gate,
    output logic clk_gate,
    output logic io_gate
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    sc_ctrl_s ctl_d, ctl_q;
    logic     raw_present, present_db, tick, in_deact;

    sc_presence_filter #(.DEB_CYCLES(DEB_CYCLES)) u_pres (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_hi     (det_hi),
        .det_lo_n   (det_lo_n),
        .det_hi_en  (det_hi_en),
        .det_lo_en  (det_lo_en),
        .raw_present(raw_present),
        .present_db (present_db)
    );

    assign in_deact = (ctl_q.state == ST_DEACT);

    sc_step_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_deact),
        .tick (tick)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_act && present_db) begin
                    ctl_d.state = ST_RAMP;
                    ctl_d.sel5  = cmd_sel5;
                end
            end
            ST_RAMP: begin
                if (!raw_present || ovc) begin
                    ctl_d.state = ST_DEACT;
                    ctl_d.step  = '0;
                    ctl_d.fault = 1'b1;
                end else if (!cmd_act) begin
                    ctl_d.state = ST_DEACT;
                    ctl_d.step  = '0;
                end else if (vcc_ok) begin
                    ctl_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (!raw_present || !vcc_ok || ovc) begin
                    ctl_d.state = ST_DEACT;
                    ctl_d.step  = '0;
                    ctl_d.fault = 1'b1;
                end else if (!cmd_act) begin
                    ctl_d.state = ST_DEACT;
                    ctl_d.step  = '0;
                end
            end
            ST_DEACT: begin
                if (tick) begin
                    if (ctl_q.step == LAST_STEP)
                        ctl_d.state = ctl_q.fault ? ST_LOCK : ST_IDLE;
                    else
                        ctl_d.step = ctl_q.step + 1'b1;
                end
            end
            ST_LOCK: begin
                if (!cmd_act) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.fault = 1'b0;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.step  <= '0;
            ctl_q.fault <= 1'b0;
            ctl_q.sel5  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Gate and supply outputs follow the state and the shutdown step
    assign rdy      = (ctl_q.state == ST_ACTIVE);
    assign rst_gate = (ctl_q.state == ST_ACTIVE);
    assign clk_gate = (ctl_q.state == ST_ACTIVE) || (in_deact && ctl_q.step == 2'd0);
    assign io_gate  = (ctl_q.state == ST_ACTIVE) || (in_deact && ctl_q.step <= 2'd1);
    assign vcc_en   = (ctl_q.state == ST_RAMP) || (ctl_q.state == ST_ACTIVE)
                    || (in_deact && ctl_q.step != LAST_STEP);
    assign vcc_sel5 = ctl_q.sel5;
    assign irq_n    = present_db & ~ctl_q.fault;
endmodule

// File: rtl/sc_fault_supervisor_chk.sv
module sc_fault_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_act,
    input logic cmd_sel5,
    input logic vcc_ok,
    input logic ovc,
    input logic irq_n,
    input logic rdy,
    input logic vcc_en,
    input logic vcc_sel5,
    input logic rst_gate,
    input logic clk_gate,
    input logic io_gate
);
    // R3
    rdy_after_good_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(vcc_ok) && vcc_en);

    // R5
    supply_off_gates_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> !rst_gate && !clk_gate && !io_gate);

    // R5
    clk_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate) |-> !rst_gate);

    // R5
    io_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_gate) |-> !clk_gate);

    // R6
    ovc_closes_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc && rdy) |=> !rst_gate);

    // R4
    sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_en && $past(vcc_en)) |-> $stable(vcc_sel5));

    // R8
    active_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> irq_n);

    // R2
    supply_on_by_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> $past(cmd_act));
endmodule

bind sc_fault_supervisor sc_fault_supervisor_chk chk_i (.*);

// File: tb/sc_fault_supervisor_tb.sv
module sc_fault_supervisor_tb_top;
    localparam int CLK_P = 10;
    localparam int DEB   = 3;
    localparam int TICK  = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic cmd_act, cmd_sel5, det_hi, det_lo_n, det_hi_en, det_lo_en, vcc_ok, ovc;
    logic irq_n, rdy, vcc_en, vcc_sel5, rst_gate, clk_gate, io_gate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sc_fault_supervisor #(.DEB_CYCLES(DEB), .TICK_CYCLES(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_sel5(cmd_sel5),
        .det_hi(det_hi), .det_lo_n(det_lo_n), .det_hi_en(det_hi_en),
        .det_lo_en(det_lo_en), .vcc_ok(vcc_ok), .ovc(ovc), .irq_n(irq_n),
        .rdy(rdy), .vcc_en(vcc_en), .vcc_sel5(vcc_sel5), .rst_gate(rst_gate),
        .clk_gate(clk_gate), .io_gate(io_gate)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic insert_card();
        det_hi = 1'b1; det_hi_en = 1'b1;
        step(DEB + 1);
    endtask

    task automatic activate(input logic sel);
        cmd_sel5 = sel;
        cmd_act  = 1'b1;
        step(1);
        check("R2 vcc_en on", vcc_en, 1);
        check("R2 sel latched", vcc_sel5, sel);
        step(2);
        check("R2 gates closed in ramp", {rst_gate, clk_gate, io_gate, rdy}, 0);
        vcc_ok = 1'b1;
        step(1);
        check("R3 rdy", rdy, 1);
        check("R3 gates open", {rst_gate, clk_gate, io_gate}, 7);
    endtask

    // trigger applied at this negedge; walks R5 order
    task automatic deact_seq(input int irq_exp);
        step(1);
        check("R5 step0 rst closed", {rst_gate, clk_gate, io_gate, vcc_en}, 4'b0111);
        check("R5 rdy off", rdy, 0);
        check("R8 irq during deact", irq_n, irq_exp);
        step(TICK - 1);
        check("R5 clk held", clk_gate, 1);
        step(1);
        check("R5 clk closed", {clk_gate, io_gate, vcc_en}, 3'b011);
        step(TICK);
        check("R5 io closed", {io_gate, vcc_en}, 2'b01);
        step(TICK);
        check("R5 supply off", vcc_en, 0);
        vcc_ok = 1'b0;
        ovc    = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_act = 1'b0; cmd_sel5 = 1'b0; det_hi = 1'b0; det_lo_n = 1'b1;
        det_hi_en = 1'b1; det_lo_en = 1'b1; vcc_ok = 1'b0; ovc = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 reset irq_n", irq_n, 0);
        check("R1 reset outputs", {rdy, vcc_en, rst_gate, clk_gate, io_gate}, 0);

        // R1 sweep over every detect/enable combination, exact debounce length
        for (int c = 0; c < 16; c++) begin
            det_hi = 1'b0; det_lo_n = 1'b1;
            step(1);
            det_hi = c[0]; det_lo_n = c[1]; det_hi_en = c[2]; det_lo_en = c[3];
            step(DEB - 1);
            check("R1 debounce not yet", irq_n, 0);
            step(1);
            check("R1 presence", irq_n, int'((c[2] & c[0]) | (c[3] & ~c[1])));
        end
        // R10 immediate removal
        det_hi = 1'b1; det_hi_en = 1'b1; det_lo_en = 1'b0; det_lo_n = 1'b1;
        step(DEB + 1);
        check("R10 present before", irq_n, 1);
        det_hi = 1'b0;
        step(1);
        check("R10 removal immediate", irq_n, 0);

        // R6/R8 faults: kind 0 removal, 1 supply drop, 2 over-current
        for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 2; s++) begin
                insert_card();
                activate(s[0]);
                cmd_sel5 = ~s[0];
                step(2);
                check("R4 sel ignored", vcc_sel5, s[0]);
                if (k == 0) det_hi = 1'b0;
                else if (k == 1) vcc_ok = 1'b0;
                else ovc = 1'b1;
                deact_seq(0);
                det_hi = 1'b1;
                step(TICK + DEB + 2);
                check("R8 locked supply off", vcc_en, 0);
                check("R8 fault latched", irq_n, 0);
                cmd_act = 1'b0;
                step(1);
                check("R8 fault cleared", irq_n, 1);
                check("R8 still off", vcc_en, 0);
            end
        end

        // R7 host deactivation and reactivation
        insert_card();
        activate(1'b1);
        cmd_act = 1'b0;
        deact_seq(1);
        step(TICK);
        check("R7 no fault", irq_n, 1);
        cmd_act = 1'b1;
        step(1);
        check("R7 reactivate", vcc_en, 1);
        vcc_ok = 1'b1;
        step(1);
        check("R7 active again", rdy, 1);

        // R9 coincident host drop and over-current
        cmd_act = 1'b0; ovc = 1'b1;
        deact_seq(0);
        step(TICK);
        check("R9 fault wins in lock", irq_n, 0);
        step(1);
        check("R9 cleared after", irq_n, 1);

        // R6 over-current during ramp
        cmd_act = 1'b1;
        step(1);
        check("R6 ramp start", vcc_en, 1);
        ovc = 1'b1;
        step(1);
        check("R6 ramp fault", {irq_n, rst_gate, vcc_en}, 3'b001);
        ovc = 1'b0;
        step(4 * TICK);
        check("R6 ramp fault locked", {irq_n, vcc_en}, 0);
        cmd_act = 1'b0;
        step(1);
        check("R8 unlock", irq_n, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule